// File: doc/BRIEF.md
# Synchronizable Time-State Generator

This block divides an input clock into the machine-cycle timing of a small controller. Each machine cycle is five time states of three clocks each, fifteen clocks in all. The block reports the current state number (1 to 5), the phase within that state (1 to 3), and a one-clock marker at the start of every machine cycle. It also drives a ready flag that tells the rest of the chip when normal execution may begin.

A sync mode lets several devices, or a tester, agree on the same time state. While the sync-mode enable is high, a strobe held high for long enough pins the prescaler and state counters at zero. A fixed delay after the strobe drops, every generator fed the same strobe lands on state 1, phase 1 on the same clock edge. Both the enable and the strobe are asynchronous to the clock, so each is passed through a two-flop synchronizer first.

The controller has four modes. FREE is free running. QUAL is a qualifying strobe being timed. PINNED means the counters are held at zero. LAUNCH is the release delay. The transitions are:
- FREE to QUAL on a valid strobe rise.
- QUAL back to FREE when the strobe falls early or the enable drops.
- QUAL to PINNED when the strobe has been high for the minimum hold.
- PINNED to LAUNCH when the strobe falls.
- LAUNCH to FREE when the release delay ends.

Top module: `tstate_gen`

## Requirements
- R1: While `rst_n` is low, `tstate`, `tphase`, `cyc_start` and `run_ready` are all 0. On the first clock edge after `rst_n` rises, the outputs go to state 1, phase 1 with `cyc_start` high.
- R2: In free running, `tphase` steps 1, 2, 3 on successive clocks. When the phase wraps from 3 to 1, `tstate` steps 1 to 5 and wraps to 1, so one machine cycle is 15 clocks.
- R3: `cyc_start` is high for exactly the one clock in which the outputs have just entered state 1, phase 1, and is low on every other clock.
- R4: `sync_en` and `sync_stb` each reach the logic through two flops. When a qualifying strobe rises, the outputs first read zero after the sixth clock edge that follows the input change.
- R5: While `sync_en` is low, a strobe of any length has no effect on `tstate`, `tphase` or `cyc_start`.
- R6: A strobe that rises fewer than 4 clocks after `sync_en` rises is ignored. This holds even if the strobe then stays high past that point. Only a rise from low to high qualifies.
- R7: A qualifying strobe held high for fewer than 4 clocks leaves the counters undisturbed.
- R8: A qualifying strobe held high for 4 clocks or more forces `tstate` and `tphase` to 0 from the sixth clock edge after its rise. They stay 0 until the launch described in R9.
- R9: On the fourth clock edge after the input strobe falls, which is two clocks after its synchronized copy falls, the outputs enter state 1, phase 1 with `cyc_start` high. Free running then resumes.
- R10: `run_ready` rises on the 77th clock edge after `sync_en` falls, which is 75 clocks (five machine cycles) after the synchronized enable drops. It rises on the 75th edge after reset if `sync_en` is already low. It stays high while the enable stays low, and clears on the third edge after `sync_en` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_en | input | 1 | Sync-mode enable, asynchronous |
| sync_stb | input | 1 | Sync strobe, asynchronous |
| tstate | output | 3 | Current time state, 1 to 5; 0 while pinned or in reset |
| tphase | output | 2 | Current phase, 1 to 3; 0 while pinned or in reset |
| cyc_start | output | 1 | One-clock marker on entry to state 1, phase 1 |
| run_ready | output | 1 | Normal execution allowed |

## Verification
The hardest situations to reach from the ports are the strobe lengths and enable ages that sit exactly on the thresholds. These are a strobe rising on the third versus the fourth clock after the enable, and a strobe held three versus four clocks. Each is off by one cycle once both synchronizers and the edge detector are counted.

Directed cases place the strobe at each of these boundaries. A random phase then mixes enable toggles, strobe lengths from one to eight clocks and idle gaps. This lands strobe rises on every phase and state of the free-running count.

A bench model predicts every output on every clock. It follows the edge offsets stated in the requirements, so a pin or launch that arrives one edge early or late shows up at once.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    // Operating modes of the sync controller
    typedef enum logic [1:0] {
        M_FREE   = 2'd0,   // free running
        M_QUAL   = 2'd1,   // strobe seen, timing its length
        M_PINNED = 2'd2,   // counters held at zero
        M_LAUNCH = 2'd3    // release delay before state 1, phase 1
    } tsg_mode_e;

endpackage

// File: rtl/tsg_sync2.sv
module tsg_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end

endmodule

// File: rtl/tsg_ctrl.sv
module tsg_ctrl
    import tsg_pkg::*;
#(
    parameter int GUARD_CLKS    = 4,
    parameter int MIN_HOLD_CLKS = 4,
    parameter int RELEASE_CLKS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic stb_s,
    output logic clr
);

    localparam int AW = $clog2(GUARD_CLKS + 1);
    localparam int HW = $clog2(MIN_HOLD_CLKS + 1);
    localparam int RW = $clog2(RELEASE_CLKS + 1);

    tsg_mode_e cur, nxt;
    logic          stb_q;
    logic [AW-1:0] en_age;
    logic [HW-1:0] hold_cnt;
    logic [RW-1:0] rel_cnt;

    logic stb_rise, guard_met, hold_done, rel_done;

    assign stb_rise  = stb_s & ~stb_q;
    assign guard_met = (en_age == AW'(GUARD_CLKS));
    assign hold_done = stb_s && (hold_cnt >= HW'(MIN_HOLD_CLKS - 1));
    assign rel_done  = (rel_cnt >= RW'(RELEASE_CLKS - 1));

    // Next-mode logic
    always_comb begin
        nxt = cur;
        unique case (cur)
            M_FREE:   if (en_s && stb_rise && guard_met) nxt = M_QUAL;
            M_QUAL: begin
                if (!en_s || !stb_s)  nxt = M_FREE;
                else if (hold_done)   nxt = M_PINNED;
            end
            M_PINNED: if (!stb_s)     nxt = M_LAUNCH;
            M_LAUNCH: if (rel_done)   nxt = M_FREE;
        endcase
    end

    // Mode register and its timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur      <= M_FREE;
            stb_q    <= 1'b0;
            en_age   <= '0;
            hold_cnt <= '0;
            rel_cnt  <= '0;
        end else begin
            cur   <= nxt;
            stb_q <= stb_s;
            if (!en_s)
                en_age <= '0;
            else if (!guard_met)
                en_age <= en_age + 1'b1;
            if (cur == M_FREE)
                hold_cnt <= HW'(1);
            else if (cur == M_QUAL && stb_s && !hold_done)
                hold_cnt <= hold_cnt + 1'b1;
            if (cur == M_PINNED)
                rel_cnt <= RW'(1);
            else if (cur == M_LAUNCH && !rel_done)
                rel_cnt <= rel_cnt + 1'b1;
        end
    end

    // Output logic: counters held while pinned and during the launch delay
    always_comb begin
        unique case (cur)
            M_FREE:   clr = 1'b0;
            M_QUAL:   clr = (nxt == M_PINNED);
            M_PINNED: clr = 1'b1;
            M_LAUNCH: clr = !rel_done;
        endcase
    end

    // R8
    pinned_from_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == M_PINNED && $past(cur) != M_PINNED) |-> $past(cur) == M_QUAL);

    // R6
    qual_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == M_QUAL && $past(cur) == M_FREE) |-> $past(en_age) == AW'(GUARD_CLKS));

    // R5
    disabled_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == M_FREE && !en_s) |=> cur == M_FREE);

    // R7
    short_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == M_QUAL && !stb_s) |=> cur == M_FREE);

endmodule

// File: rtl/tsg_counter.sv
module tsg_counter #(
    parameter int STATES = 5,
    parameter int PHASES = 3,
    localparam int ST_W = $clog2(STATES + 1),
    localparam int PH_W = $clog2(PHASES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [ST_W-1:0] st,
    output logic [PH_W-1:0] ph,
    output logic            pulse
);

    logic [ST_W-1:0] st_nxt;
    logic [PH_W-1:0] ph_nxt;

    always_comb begin
        st_nxt = st;
        ph_nxt = ph;
        if (clr) begin
            st_nxt = '0;
            ph_nxt = '0;
        end else if (st == '0) begin
            st_nxt = ST_W'(1);
            ph_nxt = PH_W'(1);
        end else if (ph == PH_W'(PHASES)) begin
            ph_nxt = PH_W'(1);
            st_nxt = (st == ST_W'(STATES)) ? ST_W'(1) : st + 1'b1;
        end else begin
            ph_nxt = ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= '0;
            ph    <= '0;
            pulse <= 1'b0;
        end else begin
            st    <= st_nxt;
            ph    <= ph_nxt;
            pulse <= (st_nxt == ST_W'(1)) && (ph_nxt == PH_W'(1));
        end
    end

    // R2
    zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == '0) == (ph == '0));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && st != '0 && ph < PH_W'(PHASES)) |=> (ph == $past(ph) + 1'b1) && (st == $past(st)));

    // R3
    pulse_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (st == ST_W'(1) && ph == PH_W'(1)));

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st == '0 && ph == '0 && !pulse));

endmodule

// File: rtl/tsg_ready.sv
module tsg_ready #(
    parameter int LIMIT = 75,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    output logic ready
);

    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        if (en_s)
            cnt_nxt = '0;
        else if (cnt < CW'(LIMIT))
            cnt_nxt = cnt + 1'b1;
        else
            cnt_nxt = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            ready <= (cnt_nxt >= CW'(LIMIT));
        end
    end

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !en_s) |=> ready);

    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> !ready);

endmodule

// File: rtl/tstate_gen.sv
module tstate_gen #(
    parameter int GUARD_CLKS    = 4,
    parameter int MIN_HOLD_CLKS = 4,
    parameter int RELEASE_CLKS  = 2,
    parameter int STATES        = 5,
    parameter int PHASES        = 3,
    parameter int READY_CYCLES  = 5,
    localparam int ST_W       = $clog2(STATES + 1),
    localparam int PH_W       = $clog2(PHASES + 1),
    localparam int READY_CLKS = READY_CYCLES * STATES * PHASES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_en,
    input  logic            sync_stb,
    output logic [ST_W-1:0] tstate,
    output logic [PH_W-1:0] tphase,
    output logic            cyc_start,
    output logic            run_ready
);

    logic [1:0] pins_s;
    logic       clr;

    // R4: both asynchronous pins share one two-flop synchronizer
    tsg_sync2 #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sync_en, sync_stb}),
        .q_sync  (pins_s)
    );

    tsg_ctrl #(
        .GUARD_CLKS    (GUARD_CLKS),
        .MIN_HOLD_CLKS (MIN_HOLD_CLKS),
        .RELEASE_CLKS  (RELEASE_CLKS)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .en_s  (pins_s[1]),
        .stb_s (pins_s[0]),
        .clr   (clr)
    );

    tsg_counter #(
        .STATES (STATES),
        .PHASES (PHASES)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .st    (tstate),
        .ph    (tphase),
        .pulse (cyc_start)
    );

    tsg_ready #(.LIMIT(READY_CLKS)) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .en_s  (pins_s[1]),
        .ready (run_ready)
    );

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);

    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |-> (tstate == '0 && tphase == '0 && !cyc_start && !run_ready));

endmodule

// File: tb/sim_tstate_gen.sv
module sim_tstate_gen;

    localparam int CLK_PERIOD = 10;
    localparam int READY_LIM  = 75;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_en;
    logic       sync_stb;
    logic [2:0] tstate;
    logic [1:0] tphase;
    logic       cyc_start;
    logic       run_ready;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model
    int  m_st = 0, m_ph = 0;
    bit  m_pulse = 0;
    bit  h1 = 0, h2 = 0;
    int  rc = 0;
    int  en_ticks = 0;

    tstate_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_en   (sync_en),
        .sync_stb  (sync_stb),
        .tstate    (tstate),
        .tphase    (tphase),
        .cyc_start (cyc_start),
        .run_ready (run_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int adv_ph(input int st, input int ph);
        if (st == 0) return 1;
        return (ph == 3) ? 1 : ph + 1;
    endfunction

    function automatic int adv_st(input int st, input int ph);
        if (st == 0) return 1;
        if (ph != 3) return st;
        return (st == 5) ? 1 : st + 1;
    endfunction

    // One clock: advance the model, then compare away from the edge
    task automatic tick(input bit zexp, input string tag);
        int ns, np;
        @(posedge clk);
        if (h2) rc = 0; else if (rc < READY_LIM) rc++;
        h2 = h1;
        h1 = sync_en;
        if (sync_en) begin if (en_ticks < 1000) en_ticks++; end else en_ticks = 0;
        if (zexp) begin
            ns = 0; np = 0;
        end else begin
            ns = adv_st(m_st, m_ph);
            np = adv_ph(m_st, m_ph);
        end
        m_pulse = (ns == 1 && np == 1);
        m_st = ns;
        m_ph = np;
        @(negedge clk);
        check(int'(tstate) == m_st, tag, "tstate", int'(tstate), m_st);
        check(int'(tphase) == m_ph, tag, "tphase", int'(tphase), m_ph);
        check(cyc_start == m_pulse, tag, "cyc_start", int'(cyc_start), int'(m_pulse));
        check(run_ready == (rc >= READY_LIM), "R10", "run_ready",
              int'(run_ready), int'(rc >= READY_LIM));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, tag);
    endtask

    // Strobe high for h clocks, then four clocks with it low
    task automatic strobe(input int h);
        bit hon;
        string tg;
        hon = sync_en && (en_ticks >= 4) && (h >= 4);
        sync_stb = 1'b1;
        for (int e = 1; e <= h + 4; e++) begin
            if (e == h + 1) sync_stb = 1'b0;
            if (hon) tg = (e == 6) ? "R4" : (e <= h + 3) ? "R8" : "R9";
            else     tg = !sync_en ? "R5" : (h < 4) ? "R7" : "R6";
            tick(hon && e >= 6 && e <= h + 3, tg);
        end
    endtask

    task automatic set_en(input bit v);
        sync_en = v;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        sync_en = 1'b0;
        sync_stb = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tstate == 0 && tphase == 0, "R1", "reset state/phase",
                  int'(tstate) * 4 + int'(tphase), 0);
            check(!cyc_start && !run_ready, "R1", "reset flags",
                  int'(cyc_start) * 2 + int'(run_ready), 0);
        end
        rst_n = 1'b1;
        tick(1'b0, "R1");
        idle(80, "R2");          // R3 pulses and R10 ready from reset

        // R6: strobe two clocks after enable, held long
        set_en(1'b1);
        idle(2, "R6");
        strobe(6);
        idle(3, "R6");
        // R6: exactly three clocks after enable
        set_en(1'b0); idle(3, "R10");
        set_en(1'b1); idle(3, "R6");
        strobe(5);
        idle(4, "R2");
        // R7: three-clock strobe
        strobe(3);
        idle(3, "R7");
        // R8 / R9: four-clock strobe, then a long one
        strobe(4);
        idle(20, "R9");
        strobe(8);
        idle(5, "R9");
        // R4 / R6: exactly four clocks after enable
        set_en(1'b0); idle(3, "R10");
        set_en(1'b1); idle(4, "R4");
        strobe(4);
        idle(5, "R9");
        // R5: enable low
        set_en(1'b0);
        idle(4, "R5");
        strobe(7);
        idle(80, "R10");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int r;
            r = int'($urandom % 4);
            if (r == 0) set_en(~sync_en);
            if (r <= 1) idle(int'($urandom % 7), "R6");
            strobe(1 + int'($urandom % 8));
            idle(3 + int'($urandom % 18), "R2");
        end
        set_en(1'b0);
        idle(80, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule